// File: doc/BRIEF.md
# External Interrupt Edge and Level Detector

This block watches four external interrupt pins, numbered 0 to 3. Every pin passes through a two-stage synchroniser. A per-pin trigger mode then decides which condition raises that pin's request flag: a rising edge, a falling edge, both edges, or, on pins 0 and 1 only, an active high or active low level. Software clears edge flags by writing ones. An enable mask decides which flags may reach the processor. The block presents one registered request at a time: the lowest-numbered enabled flag, together with its fixed vector address.

Pin 3 is not sampled directly. It first passes through a digital noise filter. The filter samples either on every cycle or on every 64th cycle, and its output moves only after two samples in a row agree. Pins 2 and 3 also emit a one-cycle event pulse on every qualifying edge, which a neighbouring counter can count. Configuration uses a small write-only register port with four addresses. Address 0 holds the modes. Address 1 holds the enables. Address 2 takes write-one-to-clear. Address 3 holds the filter clock select.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset: every enable is 0, every flag is 0, every mode is falling-edge (code 1), and the filter select is 0. Consequently `irq_req`, `irq_pending`, `tmr_evt` and `irq_vector` all read 0.
- R2: Mode code 0 (rising) sets the pin's flag on a 0-to-1 transition. A 1-to-0 transition leaves the flag at 0.
- R3: Mode code 1 (falling) sets the flag on a 1-to-0 transition and ignores 0-to-1.
- R4: Mode code 2 (both) sets the flag on each transition in either direction.
- R5: On pins 0 and 1, mode code 3 makes the flag follow the pin while it is high, and mode code 4 makes it follow while the pin is low. A clear write has no effect on a level-mode flag while its level is active.
- R6: On pins 2 and 3, mode codes 3 and 4 never set a flag and never emit an event.
- R7: A write to address 2 clears exactly the edge flags whose data bits are 1. Other flags keep their state.
- R8: Enables are written at address 1, with bit i for pin i. A pending flag whose enable is 0 is visible in `irq_pending` but never raises `irq_req`.
- R9: `irq_req` reports the lowest-numbered pending enabled pin on `irq_id`. Its `irq_vector` is 03h, 0Bh, 13h or 1Bh for pins 0 to 3.
- R10: `tmr_evt[0]` pulses for one cycle on each qualifying edge of pin 2, and `tmr_evt[1]` does the same for pin 3.
- R11: Filter select 0 is written as bit 0 of address 3. With it, a 1-cycle pulse on pin 3 is rejected, and a pulse held for 2 cycles is accepted.
- R12: Filter select 1 samples on every 64th cycle. With it, a 40-cycle pulse on pin 3 is rejected, and a 130-cycle pulse is accepted.
- R13: Pins 0, 1 and 2 register a pulse only one cycle wide.
- Mode fields are 3 bits wide, with pin i's field at bits 3i+2..3i of address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | 4 | Asynchronous interrupt pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 modes, 1 enables, 2 clear, 3 filter select |
| reg_wdata | input | 12 | Write data |
| irq_pending | output | 4 | Request flags, one per pin |
| irq_req | output | 1 | An enabled flag is pending |
| irq_id | output | 2 | Number of the winning pin |
| irq_vector | output | 8 | Vector address of the winning pin |
| tmr_evt | output | 2 | Event pulses for pins 2 and 3 |

## Verification
The bench drives pulses at the acceptance limits. One-cycle pulses on the plain pins must register, while pin 3 must reject them. Pin 3 must also accept 2-cycle pulses, and in the slow filter setting it must reject 40-cycle pulses and accept 130-cycle ones. A filter that updates on a single sample, or that does not wait for the divided clock, would let the short pulses through. A scoreboard holds the expected timer events, so a missing edge, a doubled pulse, or an event from a level mode shows up as an unmatched pulse or a leftover entry. The bench also raises several pins at once and clears their flags one at a time, watching the vector step from 0Bh to 13h to 1Bh. It writes level modes on pins 2 and 3, where a design that honoured them would raise flags.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [2:0] {
    TRIG_RISE = 3'd0,
    TRIG_FALL = 3'd1,
    TRIG_BOTH = 3'd2,
    TRIG_HIGH = 3'd3,
    TRIG_LOW  = 3'd4
  } trig_e;
  localparam int unsigned TRIG_W = $bits(trig_e);
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/irq_noise_filter.sv
module irq_noise_filter #(
  parameter int unsigned DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_sel,
  input  logic d,
  output logic q
);
  logic [DIV_LOG2-1:0] div_q;
  logic                samp_q;
  logic                tick;

  assign tick = slow_sel ? (div_q == {DIV_LOG2{1'b1}}) : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      samp_q <= 1'b0;
      q      <= 1'b0;
    end else begin
      div_q <= div_q + 1'b1;
      if (tick) begin
        samp_q <= d;
        if (d == samp_q) q <= d;
      end
    end
  end

  // R11 / R12: output may only move on a sampling tick
  a_r11_move_on_tick: assert property (@(posedge clk) disable iff (rst)
    (q != $past(q)) |-> $past(tick));
endmodule

// File: rtl/irq_trig_cell.sv
module irq_trig_cell
  import ext_irq_pkg::*;
#(
  parameter bit LEVEL_OK = 1'b0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  lv,
  input  trig_e mode,
  input  logic  clr,
  output logic  flag,
  output logic  evt
);
  logic prev_q;
  logic rise, fall, hit, lvl_mode, lvl_act;

  assign rise = lv & ~prev_q;
  assign fall = ~lv & prev_q;

  always_comb begin
    case (mode)
      TRIG_RISE: hit = rise;
      TRIG_FALL: hit = fall;
      TRIG_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  assign lvl_mode = LEVEL_OK && (mode == TRIG_HIGH || mode == TRIG_LOW);
  assign lvl_act  = (mode == TRIG_HIGH) ? lv : ~lv;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      flag   <= 1'b0;
      evt    <= 1'b0;
    end else begin
      prev_q <= lv;
      evt    <= hit;
      if (lvl_mode)  flag <= lvl_act;
      else if (hit)  flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
    end
  end

  // R2 / R6: a flag rises only from a detected edge or an active level mode
  a_r2_flag_has_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(hit || lvl_mode));
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_IRQ   = 4,
  parameter int unsigned NUM_LEVEL = 2,
  parameter int unsigned EVT_BASE  = 2,
  parameter int unsigned FILT_LOG2 = 6,
  parameter int unsigned VEC_W     = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h03,
  parameter int unsigned VEC_STEP  = 8,
  localparam int unsigned ID_W     = $clog2(NUM_IRQ),
  localparam int unsigned DATA_W   = NUM_IRQ * TRIG_W,
  localparam int unsigned EVT_N    = NUM_IRQ - EVT_BASE,
  localparam int unsigned FILT_IDX = NUM_IRQ - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IRQ-1:0] irq_pin,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [NUM_IRQ-1:0] irq_pending,
  output logic              irq_req,
  output logic [ID_W-1:0]   irq_id,
  output logic [VEC_W-1:0]  irq_vector,
  output logic [EVT_N-1:0]  tmr_evt
);
  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_EN   = 2'd1;
  localparam logic [1:0] ADDR_CLR  = 2'd2;
  localparam logic [1:0] ADDR_FILT = 2'd3;

  logic [DATA_W-1:0]  mode_q;
  logic [NUM_IRQ-1:0] en_q;
  logic               slow_q;
  logic [NUM_IRQ-1:0] clr_vec;
  logic [NUM_IRQ-1:0] sync_q;
  logic [NUM_IRQ-1:0] lv;
  logic [NUM_IRQ-1:0] evt_all;
  logic               filt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= {NUM_IRQ{TRIG_FALL}};
      en_q   <= '0;
      slow_q <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        ADDR_MODE: mode_q <= reg_wdata;
        ADDR_EN:   en_q   <= reg_wdata[NUM_IRQ-1:0];
        ADDR_FILT: slow_q <= reg_wdata[0];
        default:   ;
      endcase
    end
  end

  assign clr_vec = (reg_we && reg_addr == ADDR_CLR) ? reg_wdata[NUM_IRQ-1:0] : '0;

  irq_sync #(.WIDTH(NUM_IRQ)) u_sync (
    .clk(clk), .rst(rst), .d(irq_pin), .q(sync_q)
  );

  irq_noise_filter #(.DIV_LOG2(FILT_LOG2)) u_filt (
    .clk(clk), .rst(rst), .slow_sel(slow_q), .d(sync_q[FILT_IDX]), .q(filt_q)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_ch
    if (i == FILT_IDX) begin : g_filtered
      assign lv[i] = filt_q;
    end else begin : g_direct
      assign lv[i] = sync_q[i];
    end
    irq_trig_cell #(.LEVEL_OK(i < NUM_LEVEL)) u_cell (
      .clk(clk), .rst(rst), .lv(lv[i]),
      .mode(trig_e'(mode_q[i*TRIG_W +: TRIG_W])),
      .clr(clr_vec[i]), .flag(irq_pending[i]), .evt(evt_all[i])
    );
    // R10: every event pulse coincides with the flag it sets
    a_r10_evt_with_flag: assert property (@(posedge clk) disable iff (rst)
      evt_all[i] |-> irq_pending[i]);
  end

  assign tmr_evt = evt_all[NUM_IRQ-1:EVT_BASE];

  logic [NUM_IRQ-1:0] act;
  logic               win;
  logic [ID_W-1:0]    win_id;
  logic [VEC_W-1:0]   win_vec;

  assign act = irq_pending & en_q;

  always_comb begin
    win    = 1'b0;
    win_id = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (act[i]) begin
        win    = 1'b1;
        win_id = ID_W'(i);
      end
    end
    win_vec = VEC_BASE + VEC_W'(win_id) * VEC_W'(VEC_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req    <= 1'b0;
      irq_id     <= '0;
      irq_vector <= '0;
    end else begin
      irq_req    <= win;
      irq_id     <= win_id;
      irq_vector <= win ? win_vec : '0;
    end
  end

  // R1: outputs quiet on the first cycle out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_req && irq_pending == '0 && tmr_evt == '0));
  // R8: a request needs an enabled pending flag one cycle earlier
  a_r8_req_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ($past(irq_pending & en_q) != '0));
endmodule

// File: tb/test_ext_irq_unit.sv
`timescale 1ns/1ps
module test_ext_irq_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  irq_pin = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [11:0] reg_wdata = '0;
  logic [3:0]  irq_pending;
  logic        irq_req;
  logic [1:0]  irq_id;
  logic [7:0]  irq_vector;
  logic [1:0]  tmr_evt;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_unit i_ext_irq_unit (
    .clk(clk), .rst(rst), .irq_pin(irq_pin), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_pending(irq_pending),
    .irq_req(irq_req), .irq_id(irq_id), .irq_vector(irq_vector),
    .tmr_evt(tmr_evt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [11:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int pin, input int len);
    @(negedge clk);
    irq_pin[pin] = 1'b1;
    repeat (len) @(negedge clk);
    irq_pin[pin] = 1'b0;
  endtask

  function automatic logic [11:0] modes(input logic [2:0] m3, m2, m1, m0);
    return {m3, m2, m1, m0};
  endfunction

  // monitor: pops expected timer events (R10)
  always @(negedge clk) begin
    if (!rst) begin
      for (int k = 0; k < 2; k++) begin
        if (tmr_evt[k]) begin
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R10 unexpected event actual %0d expected none", k + 2);
          end else begin
            int e;
            e = exp_q.pop_front();
            if (e != k + 2) begin
              errors++;
              $display("FAIL R10 event actual %0d expected %0d", k + 2, e);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    chk("R1 pending", irq_pending, 4'h0);
    chk("R1 req", irq_req, 1'b0);
    chk("R1 evt", tmr_evt, 2'b00);
    chk("R1 vector", irq_vector, 8'h00);

    // R13 + R8: single-cycle pulse, default falling mode, disabled
    pulse(1, 1); idle(6);
    chk("R13 pin1 pending", irq_pending, 4'b0010);
    chk("R8 disabled no req", irq_req, 1'b0);
    wr(2'd1, 12'h002); idle(3);
    chk("R8 enabled req", irq_req, 1'b1);
    chk("R9 id pin1", irq_id, 2'd1);
    chk("R9 vector pin1", irq_vector, 8'h0B);
    wr(2'd2, 12'h002); idle(3);
    chk("R7 cleared", irq_pending, 4'h0);
    chk("R7 req dropped", irq_req, 1'b0);
    exp_q.push_back(2);
    pulse(2, 1); idle(6);
    chk("R13 pin2 pending", irq_pending, 4'b0100);
    pulse(0, 1); idle(6);
    chk("R13 pin0 pending", irq_pending, 4'b0101);
    wr(2'd2, 12'h00F); idle(3);

    // R2 rising
    wr(2'd0, modes(3'd0, 3'd0, 3'd0, 3'd0));
    @(negedge clk); irq_pin[0] = 1'b1; idle(6);
    chk("R2 rise sets", irq_pending, 4'b0001);
    wr(2'd2, 12'h001); idle(3);
    irq_pin[0] = 1'b0; idle(6);
    chk("R2 fall ignored", irq_pending, 4'b0000);

    // R3 falling
    wr(2'd0, modes(3'd1, 3'd1, 3'd1, 3'd1));
    @(negedge clk); irq_pin[1] = 1'b1; idle(6);
    chk("R3 rise ignored", irq_pending, 4'b0000);
    irq_pin[1] = 1'b0; idle(6);
    chk("R3 fall sets", irq_pending, 4'b0010);
    wr(2'd2, 12'h00F); idle(3);

    // R4 both edges on pin 2
    wr(2'd0, modes(3'd2, 3'd2, 3'd2, 3'd2));
    exp_q.push_back(2);
    @(negedge clk); irq_pin[2] = 1'b1; idle(6);
    chk("R4 rise sets", irq_pending, 4'b0100);
    wr(2'd2, 12'h004); idle(3);
    chk("R4 cleared", irq_pending, 4'b0000);
    exp_q.push_back(2);
    irq_pin[2] = 1'b0; idle(6);
    chk("R4 fall sets", irq_pending, 4'b0100);
    wr(2'd2, 12'h00F); idle(3);

    // R9 priority and vectors
    wr(2'd0, modes(3'd0, 3'd0, 3'd0, 3'd0));
    wr(2'd1, 12'h00F);
    exp_q.push_back(2);
    exp_q.push_back(3);
    @(negedge clk); irq_pin[3:1] = 3'b111; idle(10);
    chk("R9 req", irq_req, 1'b1);
    chk("R9 lowest id", irq_id, 2'd1);
    chk("R9 vec 0B", irq_vector, 8'h0B);
    wr(2'd2, 12'h002); idle(3);
    chk("R9 vec 13", irq_vector, 8'h13);
    wr(2'd2, 12'h004); idle(3);
    chk("R9 vec 1B", irq_vector, 8'h1B);
    wr(2'd2, 12'h008); idle(3);
    chk("R9 none", irq_req, 1'b0);
    irq_pin[3:1] = 3'b000; idle(10);
    @(negedge clk); irq_pin[0] = 1'b1; idle(6);
    chk("R9 vec 03", irq_vector, 8'h03);
    wr(2'd2, 12'h001);
    irq_pin[0] = 1'b0; idle(6);

    // R7 partial clear
    @(negedge clk); irq_pin[1:0] = 2'b11; idle(6);
    chk("R7 both set", irq_pending, 4'b0011);
    wr(2'd2, 12'h001); idle(3);
    chk("R7 only bit0 cleared", irq_pending, 4'b0010);
    wr(2'd2, 12'h002);
    irq_pin[1:0] = 2'b00; idle(6);

    // R5 level modes on pins 0 and 1
    wr(2'd0, modes(3'd0, 3'd0, 3'd4, 3'd3)); idle(6);
    chk("R5 low level active", irq_pending, 4'b0010);
    irq_pin[1] = 1'b1; idle(6);
    chk("R5 low level released", irq_pending, 4'b0000);
    irq_pin[0] = 1'b1; idle(6);
    chk("R5 high level active", irq_pending, 4'b0001);
    wr(2'd2, 12'h001); idle(3);
    chk("R5 clear no effect", irq_pending, 4'b0001);
    irq_pin[0] = 1'b0; idle(6);
    chk("R5 high level released", irq_pending, 4'b0000);
    irq_pin[1] = 1'b0; idle(6);
    chk("R5 low level again", irq_pending, 4'b0010);
    wr(2'd0, modes(3'd0, 3'd0, 3'd0, 3'd0));
    wr(2'd2, 12'h00F); idle(3);

    // R6 level codes on pins 2 and 3 do nothing
    wr(2'd0, modes(3'd4, 3'd3, 3'd0, 3'd0)); idle(6);
    chk("R6 low on pin3 ignored", irq_pending, 4'b0000);
    @(negedge clk); irq_pin[2] = 1'b1; idle(6);
    chk("R6 high on pin2 ignored", irq_pending, 4'b0000);
    irq_pin[2] = 1'b0; idle(6);
    chk("R6 no req", irq_req, 1'b0);

    // R11 filter at full rate
    wr(2'd0, modes(3'd0, 3'd0, 3'd0, 3'd0));
    wr(2'd3, 12'h000);
    pulse(3, 1); idle(10);
    chk("R11 1-cycle rejected", irq_pending, 4'b0000);
    exp_q.push_back(3);
    pulse(3, 2); idle(10);
    chk("R11 2-cycle accepted", irq_pending, 4'b1000);
    wr(2'd2, 12'h008); idle(6);

    // R12 filter at 1/64
    wr(2'd3, 12'h001);
    pulse(3, 40); idle(200);
    chk("R12 40-cycle rejected", irq_pending, 4'b0000);
    exp_q.push_back(3);
    pulse(3, 130); idle(200);
    chk("R12 130-cycle accepted", irq_pending, 4'b1000);
    wr(2'd2, 12'h008); idle(5);

    chk("R10 all events seen", exp_q.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule